// File: doc/BRIEF.md
# Superframe CRC-12 Generator and Checker with Block Error Counting

This block runs a 12-bit cyclic redundancy check over the payload bits of each superframe in both directions of a digital subscriber line transceiver. On the transmit side it gathers the covered payload bits, which are the two bearer channels, the signalling channel and the fourth maintenance bit, and hands out the finished checksum once per superframe so that the framer can place it in the overhead bit positions. On the receive side it computes the same checksum over the arriving covered bits. At the end of the superframe it compares that value with the checksum carried in the received overhead.

The compare result becomes a far-end error indication. This bit is held for the whole of the next superframe, so that the framer can send it back toward the other end. It reads 1 for a clean superframe and 0 for a corrupted one. A readable 8-bit counter starts at 0xFF and counts down once for every received superframe that was flagged bad, either by the local compare or by the error bit returned from the far end. It stops at zero. The host can reload the counter to 0xFF.

Top module: `sf_crc12_monitor`

## Requirements
- R1: The checksum uses the generator x^12+x^11+x^3+x^2+x+1 (mask 0x80F, with bit 11 as the most significant bit). Bits are shifted in most significant first, and the register starts from zero in every superframe. One cycle after the `tx_sf_end` cycle, `tx_crc` shows the checksum of that transmit superframe and `tx_crc_valid` is high for exactly that one cycle.
- R2: A bit enters the checksum only in a cycle where its qualify strobe (`tx_bit_vld` or `rx_bit_vld`) is 1. Bits offered while the strobe is 0 have no effect on the result.
- R3: The strobe cycle `rx_sf_end` ends the receive superframe, and a bit qualified in that same cycle is the last bit included. The block then compares the computed checksum with `rx_crc`. One cycle later `febe_tx` becomes 1 if the two match and 0 if they differ. It keeps that value until the next `rx_sf_end`.
- R4: After reset, `bec_count` is 0xFF, `febe_tx` is 1 and `tx_crc_valid` is 0.
- R5: At an `rx_sf_end`, if `rx_febe` is 0 or the local compare fails, `bec_count` drops by exactly 1 in the following cycle. When both conditions hold in the same superframe, it still drops by only 1.
- R6: `bec_count` holds at 0x00 when further errored superframes arrive and never wraps.
- R7: A pulse on `bec_reload` sets `bec_count` to 0xFF in the next cycle. If the pulse coincides with a decrement condition, the reload wins.
- R8: A superframe with no qualified bits has a checksum of 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_bit_vld | input | 1 | Transmit bit is a covered payload bit |
| tx_bit | input | 1 | Transmit serial bit |
| tx_sf_end | input | 1 | Last cycle of the transmit superframe |
| tx_crc | output | 12 | Checksum of the last finished transmit superframe |
| tx_crc_valid | output | 1 | One-cycle pulse when `tx_crc` is updated |
| rx_bit_vld | input | 1 | Receive bit is a covered payload bit |
| rx_bit | input | 1 | Receive serial bit |
| rx_sf_end | input | 1 | Last cycle of the receive superframe |
| rx_crc | input | 12 | Checksum taken from the received overhead, valid with `rx_sf_end` |
| rx_febe | input | 1 | Far-end error bit received, 0 means error, valid with `rx_sf_end` |
| febe_tx | output | 1 | Error bit to send back: 1 means clean, 0 means error |
| bec_reload | input | 1 | Host pulse that reloads the counter to 0xFF |
| bec_count | output | 8 | Block error counter |

## Verification
A host reload and an error decrement can land on the same clock edge, and so can the two error sources, far-end and local. The bench forces the first case by pulsing `bec_reload` in the exact `rx_sf_end` cycle of a superframe whose checksum has been corrupted, and expects 0xFF rather than 0xFE. It forces the second case by corrupting the checksum while also driving `rx_febe` low, and expects the count to fall by exactly one.

// File: rtl/sfcrc_pkg.sv
package sfcrc_pkg;
  localparam int          CRC_W     = 12;
  localparam logic [11:0] CRC_POLY  = 12'h80F;
  localparam int          CNT_W     = 8;

  // One serial step, most significant bit first, no augmentation.
  function automatic logic [CRC_W-1:0] crc12_step(input logic [CRC_W-1:0] cur,
                                                  input logic             din);
    logic fb;
    fb = cur[CRC_W-1] ^ din;
    crc12_step = {cur[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/sfcrc_engine.sv
module sfcrc_engine
  import sfcrc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             sf_end,
  output logic [CRC_W-1:0] crc_final,
  output logic [CRC_W-1:0] crc_run
);
  logic [CRC_W-1:0] acc_q;
  logic [CRC_W-1:0] acc_step;

  always_comb begin
    acc_step = bit_vld ? crc12_step(acc_q, bit_in) : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (sf_end) acc_q <= '0;
    else             acc_q <= acc_step;
  end

  assign crc_final = acc_step;
  assign crc_run   = acc_q;

  // R1: accumulator restarts from zero after every superframe end
  assert_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sf_end |=> (acc_q == '0));

  // R2: no qualified bit means no change within a superframe
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld && !sf_end) |=> $stable(acc_q));
endmodule

// File: rtl/sfcrc_rx_check.sv
module sfcrc_rx_check
  import sfcrc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sf_end,
  input  logic [CRC_W-1:0] crc_calc,
  input  logic [CRC_W-1:0] crc_line,
  output logic             blk_ok,
  output logic             febe_q
);
  assign blk_ok = (crc_calc == crc_line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      febe_q <= 1'b1;
    else if (sf_end) febe_q <= blk_ok;
  end

  // R3: the returned error bit only moves at a superframe boundary
  assert_febe_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_end |=> $stable(febe_q));
endmodule

// File: rtl/sfcrc_err_counter.sv
module sfcrc_err_counter
  import sfcrc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_req,
  input  logic             reload,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_FULL = '1;
  logic at_floor;
  assign at_floor = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= CNT_FULL;
    else if (reload)               cnt <= CNT_FULL;
    else if (dec_req && !at_floor) cnt <= cnt - 1'b1;
  end

  // R6: no wrap below zero
  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_floor && !reload) |=> (cnt == '0));

  // R5: at most a single step down per cycle
  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) - 1'b1)));

  // R7: reload always lands on full scale
  assert_reload_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt == CNT_FULL));
endmodule

// File: rtl/sf_crc12_monitor.sv
module sf_crc12_monitor
  import sfcrc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_bit_vld,
  input  logic             tx_bit,
  input  logic             tx_sf_end,
  output logic [CRC_W-1:0] tx_crc,
  output logic             tx_crc_valid,
  input  logic             rx_bit_vld,
  input  logic             rx_bit,
  input  logic             rx_sf_end,
  input  logic [CRC_W-1:0] rx_crc,
  input  logic             rx_febe,
  output logic             febe_tx,
  input  logic             bec_reload,
  output logic [CNT_W-1:0] bec_count
);
  logic [CRC_W-1:0] tx_final, tx_run;
  logic [CRC_W-1:0] rx_final, rx_run;
  logic             rx_blk_ok;
  logic             blk_err_evt;

  sfcrc_engine u_tx_crc (
    .clk(clk), .rst_n(rst_n), .bit_vld(tx_bit_vld), .bit_in(tx_bit),
    .sf_end(tx_sf_end), .crc_final(tx_final), .crc_run(tx_run));

  sfcrc_engine u_rx_crc (
    .clk(clk), .rst_n(rst_n), .bit_vld(rx_bit_vld), .bit_in(rx_bit),
    .sf_end(rx_sf_end), .crc_final(rx_final), .crc_run(rx_run));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_crc       <= '0;
      tx_crc_valid <= 1'b0;
    end else begin
      tx_crc_valid <= tx_sf_end;
      if (tx_sf_end) tx_crc <= tx_final;
    end
  end

  sfcrc_rx_check u_rx_chk (
    .clk(clk), .rst_n(rst_n), .sf_end(rx_sf_end), .crc_calc(rx_final),
    .crc_line(rx_crc), .blk_ok(rx_blk_ok), .febe_q(febe_tx));

  // Either far-end or near-end trouble yields one event per superframe.
  assign blk_err_evt = rx_sf_end && (!rx_febe || !rx_blk_ok);

  sfcrc_err_counter u_bec (
    .clk(clk), .rst_n(rst_n), .dec_req(blk_err_evt), .reload(bec_reload),
    .cnt(bec_count));

  // R1: valid pulse follows a transmit superframe end by one cycle
  assert_tx_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sf_end |=> tx_crc_valid);
  assert_tx_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_sf_end |=> ($stable(tx_crc) && !tx_crc_valid));

  // R5: a clean, non-reloaded superframe end leaves the counter alone
  assert_clean_no_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sf_end && rx_febe && rx_blk_ok && !bec_reload) |=> $stable(bec_count));
endmodule

// File: tb/sf_crc12_monitor_tb.sv
module sf_crc12_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_bit_vld = 0, tx_bit = 0, tx_sf_end = 0;
  logic [11:0] tx_crc;
  logic        tx_crc_valid;
  logic        rx_bit_vld = 0, rx_bit = 0, rx_sf_end = 0;
  logic [11:0] rx_crc = '0;
  logic        rx_febe = 1;
  logic        febe_tx;
  logic        bec_reload = 0;
  logic [7:0]  bec_count;

  int checks = 0, failures = 0;
  int exp_cnt = 255;

  always #(CLK_PERIOD/2) clk = ~clk;

  sf_crc12_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .tx_bit_vld(tx_bit_vld), .tx_bit(tx_bit),
    .tx_sf_end(tx_sf_end), .tx_crc(tx_crc), .tx_crc_valid(tx_crc_valid),
    .rx_bit_vld(rx_bit_vld), .rx_bit(rx_bit), .rx_sf_end(rx_sf_end),
    .rx_crc(rx_crc), .rx_febe(rx_febe), .febe_tx(febe_tx),
    .bec_reload(bec_reload), .bec_count(bec_count));

  // {data, nbits, corrupt crc, far-end bit, gaps between bits}
  typedef struct packed {
    logic [15:0] data;
    logic [4:0]  nbits;
    logic        corrupt;
    logic        febe_in;
    logic        gaps;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{16'h0001, 5'd1,  1'b0, 1'b1, 1'b0},
    '{16'hA5C3, 5'd16, 1'b0, 1'b1, 1'b0},
    '{16'hFFFF, 5'd16, 1'b1, 1'b1, 1'b0},
    '{16'h1234, 5'd16, 1'b0, 1'b0, 1'b1},
    '{16'h0F0F, 5'd12, 1'b0, 1'b1, 1'b1},
    '{16'h8000, 5'd16, 1'b1, 1'b0, 1'b0},
    '{16'h0055, 5'd8,  1'b0, 1'b1, 1'b0},
    '{16'h7E81, 5'd16, 1'b0, 1'b1, 1'b1},
    '{16'h0003, 5'd2,  1'b1, 1'b1, 1'b0},
    '{16'hC001, 5'd16, 1'b0, 1'b1, 1'b0}
  };

  // Remainder of M(x)*x^12 by long division with the 13-bit generator.
  function automatic logic [11:0] ref_crc(input logic [15:0] d, input int n);
    logic [12:0] rem = '0;
    for (int i = 0; i < n + 12; i++) begin
      logic b;
      b = (i < n) ? d[n-1-i] : 1'b0;
      rem = {rem[11:0], b};
      if (rem[12]) rem = rem ^ 13'h180F;
    end
    return rem[11:0];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Sends one superframe on both sides; last cycle carries the end strobe.
  task automatic send_sf(input logic [15:0] d, input int n, input logic corrupt,
                         input logic fe, input logic gaps, input logic rl);
    logic [11:0] c;
    c = ref_crc(d, n);
    if (n == 0) begin
      @(negedge clk);
      tx_bit_vld = 0; rx_bit_vld = 0; tx_bit = 1; rx_bit = 1;
      tx_sf_end = 1; rx_sf_end = 1;
      rx_crc = corrupt ? (c ^ 12'h001) : c; rx_febe = fe; bec_reload = rl;
    end
    for (int i = 0; i < n; i++) begin
      if (gaps && i > 0) begin
        @(negedge clk);
        tx_bit_vld = 0; rx_bit_vld = 0; tx_bit = 1; rx_bit = 1;
        tx_sf_end = 0; rx_sf_end = 0; bec_reload = 0;
      end
      @(negedge clk);
      tx_bit_vld = 1; rx_bit_vld = 1; tx_bit = d[n-1-i]; rx_bit = d[n-1-i];
      tx_sf_end = (i == n-1); rx_sf_end = (i == n-1);
      rx_crc = corrupt ? (c ^ 12'h001) : c; rx_febe = fe;
      bec_reload = (i == n-1) ? rl : 1'b0;
    end
    @(negedge clk);
    tx_bit_vld = 0; rx_bit_vld = 0; tx_sf_end = 0; rx_sf_end = 0; bec_reload = 0;
    if (rl) exp_cnt = 255;
    else if ((corrupt || !fe) && exp_cnt > 0) exp_cnt--;
    check("R1 tx_crc", tx_crc, c);
    check("R1 tx_crc_valid pulse", tx_crc_valid, 1);
    check("R3 febe_tx", febe_tx, !corrupt);
    check("R5 bec_count", bec_count, exp_cnt);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R4: reset state
    check("R4 bec_count reset", bec_count, 8'hFF);
    check("R4 febe_tx reset", febe_tx, 1);
    check("R4 tx_crc_valid reset", tx_crc_valid, 0);
    rst_n = 1;
    @(negedge clk);

    // Table walk: R1, R2 (gapped bits), R3, R5
    for (int v = 0; v < NVEC; v++)
      send_sf(VECS[v].data, int'(VECS[v].nbits), VECS[v].corrupt,
              VECS[v].febe_in, VECS[v].gaps, 1'b0);

    // R1: valid pulse lasts one cycle only
    @(negedge clk);
    check("R1 valid drops", tx_crc_valid, 0);

    // R8: empty superframe
    send_sf(16'h0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R8 empty crc zero", tx_crc, 0);

    // R5: both error sources at once: single decrement
    send_sf(16'h00F1, 8, 1'b1, 1'b0, 1'b0, 1'b0);

    // R6: drain to zero and keep going
    while (exp_cnt > 0) send_sf(16'h1, 1, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) send_sf(16'h1, 1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R6 floor at zero", bec_count, 0);

    // R7: plain reload
    @(negedge clk); bec_reload = 1;
    @(negedge clk); bec_reload = 0; exp_cnt = 255;
    check("R7 reload to FF", bec_count, 8'hFF);

    // R7: reload coincides with an errored superframe end
    send_sf(16'h0BAD, 16, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R7 reload wins", bec_count, 8'hFF);

    // R3: febe_tx holds during following idle cycles
    repeat (4) @(negedge clk);
    check("R3 febe_tx held", febe_tx, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule